// File: doc/BRIEF.md
# Pre-Trigger Trace Capture Buffer

This block keeps a record of a stream of ADC samples and, when a trigger arrives, keeps a fixed-length window around it. The window holds a programmable number of samples from before the trigger. The rest of the window is filled with the samples that follow the trigger. Two circular memory banks take turns. One bank records the live stream. A bank whose window has closed waits until its trace has been read out. A second event can therefore be captured while the first is still being drained.

Capture is controlled by a write state machine with three states:
- `W_ARM`: records history and waits for a trigger.
- `W_POST`: counts the post-trigger samples.
- `W_STALL`: both banks hold unread windows.

Its transitions are:
- arm to post, on a trigger whose window needs more samples;
- post to arm, on the last post sample;
- arm or post to stall, when a kept window closes and the other bank is still full;
- stall to arm, when the other bank is freed.

If a window is discarded because data reduction is on and no hit was seen, recording carries on in the same bank with its history intact.

A read state machine has two states, `R_IDLE` and `R_RUN`. It goes from idle to run as soon as the oldest full bank exists. It goes back to idle once that bank's last word has been issued, and the bank is freed at that point. The trace comes out oldest sample first, one word per accepted read request.

Top module: `trace_capture`

## Requirements
- R1: The window length is taken from `cfg_win`, clamped to the range 1 to 2^DEPTH_W. The pre-trigger count is `cfg_pre`, clamped to the window length. The post-trigger count is the window minus the pre-trigger count. When that count is zero, a sample presented in the trigger cycle is not recorded.
- R2: A trigger taken in `W_ARM` in the cycle of sample T produces a window of samples T-pre through T+post-1. The sample presented in the trigger cycle counts as the first post-trigger sample.
- R3: Readout begins at the oldest pre-trigger sample and runs in time order, including across the wrap from the top of the circular bank back to address 0.
- R4: If the bank holds fewer samples than the pre-trigger count when the trigger arrives, the window keeps its full length. The first (pre minus recorded) words come out with `rd_real`=0, and all later words with `rd_real`=1.
- R5: While `rd_avail` is high, a cycle with `rd_en` high is answered one cycle later by `rd_valid`=1 with the next word. `rd_last`=1 marks only the final word of a window.
- R6: A window that closes while another is unread is kept. Windows are read in the order in which they closed. `rd_avail` stays high until the offered window has been read completely.
- R7: After a kept window closes while the other bank is full, `busy`=1 until a bank is freed. A trigger during `busy` is refused and answered by `trig_rej`=1 in the same cycle.
- R8: With `cfg_reduce`=1, a window with no `hit` seen from its trigger cycle to its last sample is never offered, and `rd_avail` stays low.
- R9: After reset, `rd_avail`, `rd_valid` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new ADC sample is present |
| smp | input | DATA_W | ADC sample |
| trig | input | 1 | Trigger request |
| hit | input | 1 | Hit indication used by data reduction |
| cfg_win | input | DEPTH_W+1 | Requested total window length |
| cfg_pre | input | DEPTH_W+1 | Requested pre-trigger length |
| cfg_reduce | input | 1 | Drop windows that have no hit |
| rd_en | input | 1 | Read request for the next word |
| rd_avail | output | 1 | A captured window is being offered |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_data | output | DATA_W | Trace word |
| rd_real | output | 1 | The word is a recorded sample, not leading fill |
| rd_last | output | 1 | Final word of the window |
| busy | output | 1 | Both banks hold unread windows |
| trig_rej | output | 1 | A trigger was refused this cycle |

## Verification
A window closes at the clock edge of its last post-trigger sample. The read machine starts on the edge after that, and each word follows its accepted request by exactly one cycle. `busy` shows at the edge after the close, while `trig_rej` is combinational with `trig`. The bench drives inputs on falling edges and captures every `rd_valid` word on falling edges, so each result is read half a cycle after the edge that produced it. Each window check then runs only after enough idle cycles for the whole window to have drained. The one latency check samples `rd_valid` at the very next falling edge after `rd_en` is raised.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        W_ARM   = 2'd0,
        W_POST  = 2'd1,
        W_STALL = 2'd2
    } wr_state_e;

    typedef enum logic {
        R_IDLE = 1'b0,
        R_RUN  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/trc_bank.sv
module trc_bank #(
    parameter int DATA_W  = 14,
    parameter int DEPTH_W = 10,
    localparam int DEPTH  = 1 << DEPTH_W
) (
    input  logic               clk,
    input  logic               we,
    input  logic [DEPTH_W-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               re,
    input  logic [DEPTH_W-1:0] raddr,
    output logic [DATA_W-1:0]  q
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) q <= mem[raddr];
    end

endmodule

// File: rtl/trc_writer.sv
module trc_writer
    import trc_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int DEPTH_W = 10,
    localparam int CNT_W  = DEPTH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_vld,
    input  logic [DATA_W-1:0]  smp,
    input  logic               trig,
    input  logic               hit,
    input  logic [CNT_W-1:0]   cfg_win,
    input  logic [CNT_W-1:0]   cfg_pre,
    input  logic               cfg_reduce,
    input  logic [1:0]         buf_free,
    output logic               wr_en,
    output logic               wr_buf,
    output logic [DEPTH_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               busy,
    output logic               trig_rej,
    output logic               done_keep,
    output logic               done_buf,
    output logic [DEPTH_W-1:0] done_start,
    output logic [CNT_W-1:0]   done_miss,
    output logic [CNT_W-1:0]   done_len
);

    localparam logic [CNT_W-1:0] DEPTH_V = {1'b1, {DEPTH_W{1'b0}}};

    wr_state_e st, st_n;

    logic               wbuf;
    logic [DEPTH_W-1:0] wptr, start_r, start_c;
    logic [CNT_W-1:0]   fill, post_left, miss_r, len_r;
    logic [CNT_W-1:0]   win_c, pre_c, post_c, miss_c;
    logic               hit_acc, arm_trig, fin, hit_fin, keep, switch_ok, switch_now;

    // clamp the programmed window and split (R1)
    always_comb begin
        if (cfg_win == '0)          win_c = CNT_W'(1);
        else if (cfg_win > DEPTH_V) win_c = DEPTH_V;
        else                        win_c = cfg_win;
        pre_c   = (cfg_pre > win_c) ? win_c : cfg_pre;
        post_c  = win_c - pre_c;
        miss_c  = (pre_c > fill) ? (pre_c - fill) : '0;
        start_c = wptr - pre_c[DEPTH_W-1:0];
    end

    // outputs and completion decode
    always_comb begin
        arm_trig   = (st == W_ARM) && trig;
        wr_en      = smp_vld && ((st == W_POST) ||
                                 ((st == W_ARM) && !(trig && (post_c == '0))));
        if (arm_trig)
            fin = (post_c == '0) || ((post_c == CNT_W'(1)) && smp_vld);
        else
            fin = (st == W_POST) && smp_vld && (post_left == CNT_W'(1));
        hit_fin    = arm_trig ? hit : (hit_acc | hit);
        keep       = !cfg_reduce || hit_fin;
        done_keep  = fin && keep;
        done_buf   = wbuf;
        done_start = arm_trig ? start_c : start_r;
        done_miss  = arm_trig ? miss_c  : miss_r;
        done_len   = arm_trig ? win_c   : len_r;
        switch_ok  = buf_free[~wbuf];
        switch_now = (fin && keep && switch_ok) || ((st == W_STALL) && switch_ok);
        busy       = (st == W_STALL);
        trig_rej   = (st == W_STALL) && trig;
        wr_buf     = wbuf;
        wr_addr    = wptr;
        wr_data    = smp;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            W_ARM:   if (trig && !fin) st_n = W_POST;
            W_POST:  st_n = W_POST;
            W_STALL: if (switch_ok) st_n = W_ARM;
            default: st_n = W_ARM;
        endcase
        if (fin) st_n = (keep && !switch_ok) ? W_STALL : W_ARM;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= W_ARM;
        else        st <= st_n;
    end

    // write pointer, history depth and window bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbuf      <= 1'b0;
            wptr      <= '0;
            fill      <= '0;
            post_left <= '0;
            hit_acc   <= 1'b0;
            start_r   <= '0;
            miss_r    <= '0;
            len_r     <= '0;
        end else begin
            if (wr_en) begin
                wptr <= wptr + 1'b1;
                if (fill != DEPTH_V) fill <= fill + 1'b1;
            end
            if (arm_trig) begin
                start_r   <= start_c;
                miss_r    <= miss_c;
                len_r     <= win_c;
                hit_acc   <= hit;
                post_left <= post_c - CNT_W'(smp_vld);
            end else if (st == W_POST) begin
                hit_acc <= hit_acc | hit;
                if (smp_vld) post_left <= post_left - 1'b1;
            end
            if (switch_now) begin
                wbuf <= ~wbuf;
                wptr <= '0;
                fill <= '0;
            end
        end
    end

endmodule

// File: rtl/trc_reader.sv
module trc_reader
    import trc_pkg::*;
#(
    parameter int DEPTH_W = 10,
    localparam int CNT_W  = DEPTH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_keep,
    input  logic               done_buf,
    input  logic [DEPTH_W-1:0] done_start,
    input  logic [CNT_W-1:0]   done_miss,
    input  logic [CNT_W-1:0]   done_len,
    input  logic               rd_en,
    output logic [1:0]         buf_free,
    output logic               rd_avail,
    output logic               rd_re,
    output logic               rd_sel,
    output logic [DEPTH_W-1:0] rd_addr,
    output logic               rd_valid,
    output logic               rd_real,
    output logic               rd_last,
    output logic               sel_q
);

    rd_state_e st, st_n;

    logic [1:0]         full;
    logic               head;
    logic [DEPTH_W-1:0] raddr;
    logic [CNT_W-1:0]   cnt;
    logic [DEPTH_W-1:0] m_start [2];
    logic [CNT_W-1:0]   m_miss  [2];
    logic [CNT_W-1:0]   m_len   [2];
    logic               last_c, fin_read;

    // outputs
    always_comb begin
        rd_avail = (st == R_RUN);
        rd_re    = rd_avail && rd_en;
        last_c   = (cnt == (m_len[head] - CNT_W'(1)));
        fin_read = rd_re && last_c;
        rd_sel   = head;
        rd_addr  = raddr;
        buf_free = ~full;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            R_IDLE:  if (full[head]) st_n = R_RUN;
            R_RUN:   if (fin_read)   st_n = R_IDLE;
            default: st_n = R_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= R_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 2'b00;
            head     <= 1'b0;
            raddr    <= '0;
            cnt      <= '0;
            rd_valid <= 1'b0;
            rd_real  <= 1'b0;
            rd_last  <= 1'b0;
            sel_q    <= 1'b0;
            for (int i = 0; i < 2; i++) begin
                m_start[i] <= '0;
                m_miss[i]  <= '0;
                m_len[i]   <= '0;
            end
        end else begin
            if ((st == R_IDLE) && full[head]) begin
                raddr <= m_start[head];
                cnt   <= '0;
            end
            if (rd_re) begin
                raddr <= raddr + 1'b1;
                cnt   <= cnt + 1'b1;
            end
            if (fin_read) begin
                full[head] <= 1'b0;
                head       <= ~head;
            end
            if (done_keep) begin
                full[done_buf]    <= 1'b1;
                m_start[done_buf] <= done_start;
                m_miss[done_buf]  <= done_miss;
                m_len[done_buf]   <= done_len;
                if (fin_read || !full[head]) head <= done_buf;
            end
            rd_valid <= rd_re;
            rd_real  <= rd_re && (cnt >= m_miss[head]);
            rd_last  <= rd_re && last_c;
            sel_q    <= head;
        end
    end

endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
    parameter int DATA_W  = 14,
    parameter int DEPTH_W = 10,
    localparam int CNT_W  = DEPTH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp,
    input  logic              trig,
    input  logic              hit,
    input  logic [CNT_W-1:0]  cfg_win,
    input  logic [CNT_W-1:0]  cfg_pre,
    input  logic              cfg_reduce,
    input  logic              rd_en,
    output logic              rd_avail,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_real,
    output logic              rd_last,
    output logic              busy,
    output logic              trig_rej
);

    logic               wr_en, wr_buf, done_keep, done_buf, rd_re, rd_sel, sel_q;
    logic [DEPTH_W-1:0] wr_addr, rd_addr, done_start;
    logic [DATA_W-1:0]  wr_data;
    logic [CNT_W-1:0]   done_miss, done_len;
    logic [1:0]         buf_free;
    logic [DATA_W-1:0]  bank_q [2];

    trc_writer #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .trig(trig), .hit(hit),
        .cfg_win(cfg_win), .cfg_pre(cfg_pre), .cfg_reduce(cfg_reduce), .buf_free(buf_free),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .trig_rej(trig_rej), .done_keep(done_keep), .done_buf(done_buf),
        .done_start(done_start), .done_miss(done_miss), .done_len(done_len)
    );

    trc_reader #(.DEPTH_W(DEPTH_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .done_keep(done_keep), .done_buf(done_buf),
        .done_start(done_start), .done_miss(done_miss), .done_len(done_len),
        .rd_en(rd_en), .buf_free(buf_free), .rd_avail(rd_avail), .rd_re(rd_re),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_real(rd_real),
        .rd_last(rd_last), .sel_q(sel_q)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        trc_bank #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u_bank (
            .clk(clk),
            .we(wr_en && (wr_buf == 1'(b))),
            .waddr(wr_addr),
            .wdata(wr_data),
            .re(rd_re && (rd_sel == 1'(b))),
            .raddr(rd_addr),
            .q(bank_q[b])
        );
    end

    assign rd_data = bank_q[sel_q];

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk (
    input logic clk,
    input logic rst_n,
    input logic trig,
    input logic rd_en,
    input logic rd_avail,
    input logic rd_valid,
    input logic rd_real,
    input logic rd_last,
    input logic busy,
    input logic trig_rej
);

    // R5
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && rd_avail));

    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R4
    real_then_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_real && !rd_last) |=> !(rd_valid && !rd_real));

    // R6
    avail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_avail && !rd_en) |=> rd_avail);

    // R7
    busy_has_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_avail || $past(rd_avail)));

    // R7
    rej_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rej |-> (busy && trig));

endmodule

bind trace_capture trace_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rd_en(rd_en), .rd_avail(rd_avail),
    .rd_valid(rd_valid), .rd_real(rd_real), .rd_last(rd_last), .busy(busy),
    .trig_rej(trig_rej)
);

// File: tb/sim_trace_capture.sv
`timescale 1ns/1ps
module sim_trace_capture;

    localparam int DATA_W  = 14;
    localparam int DEPTH_W = 10;
    localparam int CNT_W   = DEPTH_W + 1;
    localparam int MAXC    = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic [DATA_W-1:0] smp = '0;
    logic              trig = 1'b0;
    logic              hit = 1'b0;
    logic [CNT_W-1:0]  cfg_win = '0;
    logic [CNT_W-1:0]  cfg_pre = '0;
    logic              cfg_reduce = 1'b0;
    logic              rd_en = 1'b0;
    logic              rd_avail, rd_valid, rd_real, rd_last, busy, trig_rej;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int nxt = 0;
    int ncap = 0;
    int cd [MAXC];
    bit cr [MAXC];
    bit cl [MAXC];

    always #2 clk = ~clk;

    trace_capture #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .trig(trig), .hit(hit),
        .cfg_win(cfg_win), .cfg_pre(cfg_pre), .cfg_reduce(cfg_reduce), .rd_en(rd_en),
        .rd_avail(rd_avail), .rd_valid(rd_valid), .rd_data(rd_data), .rd_real(rd_real),
        .rd_last(rd_last), .busy(busy), .trig_rej(trig_rej)
    );

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (ncap < MAXC) begin
                cd[ncap] = int'(rd_data);
                cr[ncap] = rd_real;
                cl[ncap] = rd_last;
            end
            ncap++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit tg, input bit hv);
        @(negedge clk);
        smp_vld = v;
        smp     = v ? DATA_W'(nxt) : '0;
        trig    = tg;
        hit     = hv;
        if (v) nxt++;
    endtask

    task automatic run(input int n);
        repeat (n) step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic verify(input string req, input int base, input int t,
                          input int pre, input int win, input int miss);
        int da = 0, de = 0, ra = 0, re = 0, la = 0, le = 0;
        bit bd = 0, br = 0, bl = 0;
        for (int i = 0; i < win; i++) begin
            int ed;
            bit er, el;
            ed = (t - pre + i) & ((1 << DATA_W) - 1);
            er = (i >= miss);
            el = (i == win - 1);
            if (!bd && er && cd[base+i] != ed) begin bd = 1; da = cd[base+i]; de = ed; end
            if (!br && cr[base+i] != er) begin br = 1; ra = int'(cr[base+i]); re = int'(er); end
            if (!bl && cl[base+i] != el) begin bl = 1; la = int'(cl[base+i]); le = int'(el); end
        end
        chk({req, " data"}, da, de);
        chk({req, " real flag"}, ra, re);
        chk({req, " last flag"}, la, le);
    endtask

    task automatic t_reset();
        chk("R9 rd_avail after reset", int'(rd_avail), 0);
        chk("R9 rd_valid after reset", int'(rd_valid), 0);
        chk("R9 busy after reset", int'(busy), 0);
    endtask

    task automatic t_wrap();
        int t;
        cfg_win = 11'd100; cfg_pre = 11'd30; cfg_reduce = 1'b0; rd_en = 1'b1;
        ncap = 0;
        run(1000);
        t = nxt;
        step(1'b1, 1'b1, 1'b0);
        run(69);
        idle(150);
        chk("R2 window length", ncap, 100);
        verify("R2 R3 wrapped window", 0, t, 30, 100, 0);
        chk("R5 no offer after drain", int'(rd_avail), 0);
    endtask

    task automatic t_clamp();
        int t;
        cfg_win = 11'd200; cfg_pre = 11'd300;
        ncap = 0;
        run(400);
        t = nxt;
        step(1'b1, 1'b1, 1'b0);
        idle(250);
        chk("R1 clamped length", ncap, 200);
        verify("R1 pre clamped to window", 0, t, 200, 200, 0);
    endtask

    task automatic t_invalid();
        int t;
        cfg_win = 11'd40; cfg_pre = 11'd25;
        ncap = 0;
        run(10);
        t = nxt;
        step(1'b1, 1'b1, 1'b0);
        run(14);
        idle(60);
        chk("R4 short history length", ncap, 40);
        verify("R4 leading fill marked", 0, t, 25, 40, 15);
    endtask

    task automatic t_reduce();
        int t;
        cfg_win = 11'd50; cfg_pre = 11'd10; cfg_reduce = 1'b1;
        ncap = 0;
        run(100);
        step(1'b1, 1'b1, 1'b0);
        run(39);
        idle(80);
        chk("R8 no-hit window not offered", ncap, 0);
        chk("R8 rd_avail low", int'(rd_avail), 0);
        t = nxt;
        step(1'b1, 1'b1, 1'b0);
        run(20);
        step(1'b1, 1'b0, 1'b1);
        run(18);
        idle(80);
        chk("R8 hit window length", ncap, 50);
        verify("R8 hit window", 0, t, 10, 50, 0);
        cfg_reduce = 1'b0;
    endtask

    task automatic t_double();
        int ta, tb;
        cfg_win = 11'd60; cfg_pre = 11'd20; rd_en = 1'b0;
        ncap = 0;
        run(50);
        ta = nxt;
        step(1'b1, 1'b1, 1'b0);
        run(39);
        run(50);
        tb = nxt;
        step(1'b1, 1'b1, 1'b0);
        run(39);
        idle(2);
        chk("R7 busy with both banks full", int'(busy), 1);
        chk("R6 first window offered", int'(rd_avail), 1);
        step(1'b1, 1'b1, 1'b0);
        #1;
        chk("R7 trigger refused", int'(trig_rej), 1);
        idle(1);
        chk("R6 nothing read yet", ncap, 0);
        rd_en = 1'b1;
        @(negedge clk);
        chk("R5 one-cycle read latency", int'(rd_valid), 1);
        chk("R5 first word value", int'(rd_data), (ta - 20) & ((1 << DATA_W) - 1));
        idle(200);
        chk("R6 both windows read", ncap, 120);
        verify("R6 older window first", 0, ta, 20, 60, 0);
        verify("R6 newer window second", 60, tb, 20, 60, 0);
        chk("R7 busy released", int'(busy), 0);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_wrap();
        t_clamp();
        t_invalid();
        t_reduce();
        t_double();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule